// File: doc/BRIEF.md
# ATA PIO Timing Parameter Calculator

This block turns a requested ATA PIO transfer mode and the system clock rate into the cycle counts that a memory-mapped bus controller needs to drive a storage device region. For each mode it has a fixed set of nanosecond figures: the delay from chip select to strobe, the strobe width and the hold time. It scales each figure by the clock rate and rounds up to whole cycles. It then stores each count in minus-one form. If the strobe count is too large for its field, the block halves every count, rounding up, and doubles a shared time multiplier. It repeats this until the strobe count fits.

A request is made with a one-cycle `start` pulse. The clock rate input is held static in whole MHz. Each pass of the halving loop takes one clock. The results are registered and held until the next request completes, and a one-cycle `done` pulse marks the cycle in which they change. The block also reports whether the device's ready handshake should be honoured for the mode, and it supplies two fixed fields: address setup and address-latch width. It does not generate the bus waveform and does not write any configuration register.

Top module: `ata_pio_timing`

## Requirements
- R1: Per mode, the nanosecond figures (chip-select-to-strobe / strobe / hold) are: mode 0 = 70/165/20, mode 1 = 50/125/15, mode 2 = 30/100/10, mode 3 = 30/80/10, mode 4 = 25/70/10, mode 5 = 15/65/10, mode 6 = 10/55/10. Each figure converts to cycles as ceil(ns × clk_mhz / 1000).
- R2: Each converted count that is nonzero is reduced by one. A zero count stays zero, so a `clk_mhz` of 0 gives all-zero fields.
- R3: Starting from zero doublings, while the strobe count is 64 or more and fewer than 3 doublings have been applied, every count becomes ceil(count/2) and the doubling count rises by one. A count still above 63 after that saturates to 63.
- R4: `mult_code` encodes the multiplier 1, 2, 4, 8 (0, 1, 2, 3 doublings) as 2'b01, 2'b10, 2'b00, 2'b11.
- R5: `iordy_en` is 1 for modes 0 to 4 and 0 for modes 5 and 6.
- R6: `rd_width` and `wr_width` both carry the strobe count. `rd_hold` and `wr_hold` both carry the hold count.
- R7: `addr_setup` is always 1 and `latch_cyc` is always 8.
- R8: A `mode` value of 7 gives exactly the results of mode 0.
- R9: `done` is high for exactly one cycle. It goes high 1 + (number of doublings) clock edges after the edge that samples `start`. Between `done` pulses, every computed output holds its value.
- R10: A `start` pulse that arrives while a computation is in progress is ignored. The result and latency of the running request are unchanged, whatever the `mode` and `clk_mhz` inputs are at that moment.
- R11: After reset, `done`, all computed count fields, `mult_code` and `iordy_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse; mode and clk_mhz are sampled with it |
| mode | input | 3 | Requested PIO mode, 0 to 6 (7 treated as 0) |
| clk_mhz | input | 11 | Clock rate in whole MHz, rounded up |
| done | output | 1 | One-cycle pulse when new results are present |
| setup_cyc | output | 6 | Chip-select-to-strobe delay, minus-one cycles |
| rd_width | output | 6 | Read strobe width, minus-one cycles |
| wr_width | output | 6 | Write strobe width, minus-one cycles |
| rd_hold | output | 6 | Hold after read, minus-one cycles |
| wr_hold | output | 6 | Hold after write, minus-one cycles |
| mult_code | output | 2 | Encoded time multiplier |
| iordy_en | output | 1 | Honour device ready handshake |
| addr_setup | output | 4 | Fixed address-valid-before-select field |
| latch_cyc | output | 4 | Fixed address-latch field |

## Verification
The bench drives the halving threshold from both sides. With mode 0, a clock of 387 MHz gives a strobe count of exactly 63, and 388 MHz gives 64. A design that compares with the wrong bound would halve one time too many or one time too few, and both the counts and `mult_code` would come out wrong. The highest clock rate forces three doublings, and this exposes a design that encodes the multiplier monotonically or uses a floor halving, which would lose the round-up on odd counts. A zero clock rate would expose a minus-one step that wraps to 63. Mode 7 and a `start` pulse during a running computation catch a design that decodes the mode without a default, or that restarts mid-loop with a shortened latency.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int NS_W = 8;
  localparam int NUM_T = 3;
  localparam int IDX_SETUP = 0;
  localparam int IDX_STROBE = 1;
  localparam int IDX_HOLD = 2;

  typedef logic [NUM_T-1:0][NS_W-1:0] ns_set_t;

  function automatic ns_set_t mode_ns(input logic [2:0] m);
    ns_set_t r;
    case (m)
      3'd1: r = {8'd15, 8'd125, 8'd50};
      3'd2: r = {8'd10, 8'd100, 8'd30};
      3'd3: r = {8'd10, 8'd80,  8'd30};
      3'd4: r = {8'd10, 8'd70,  8'd25};
      3'd5: r = {8'd10, 8'd65,  8'd15};
      3'd6: r = {8'd10, 8'd55,  8'd10};
      default: r = {8'd20, 8'd165, 8'd70};
    endcase
    return r;
  endfunction

  function automatic logic [1:0] mult_encode(input logic [1:0] dbl);
    case (dbl)
      2'd0: return 2'b01;
      2'd1: return 2'b10;
      2'd2: return 2'b00;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/ata_ns_lut.sv
module ata_ns_lut
  import ata_pio_pkg::*;
(
  input  logic [2:0] mode,
  output ns_set_t    ns_vals,
  output logic       iordy
);
  always_comb begin
    ns_vals = mode_ns(mode);
    iordy   = (mode <= 3'd4) || (mode == 3'd7);
  end
endmodule

// File: rtl/ata_cyc_conv.sv
module ata_cyc_conv #(
  parameter int NS_W  = 8,
  parameter int MHZ_W = 11,
  parameter int CNT_W = NS_W + MHZ_W
) (
  input  logic [NS_W-1:0]  ns,
  input  logic [MHZ_W-1:0] mhz,
  output logic [CNT_W-1:0] cyc
);
  localparam int PROD_W = NS_W + MHZ_W + 1;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] ceil_q;

  always_comb begin
    prod   = PROD_W'(ns) * PROD_W'(mhz);
    ceil_q = (prod + PROD_W'(999)) / PROD_W'(1000);
    cyc    = (ceil_q == '0) ? '0 : CNT_W'(ceil_q - PROD_W'(1));
  end
endmodule

// File: rtl/ata_fit_seq.sv
module ata_fit_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W   = 19,
  parameter int FIELD_W = 6,
  parameter int MAX_DBL = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NUM_T-1:0][CNT_W-1:0]   cnt_in,
  input  logic                          iordy_in,
  output logic                          done,
  output logic [NUM_T-1:0][FIELD_W-1:0] fields,
  output logic [1:0]                    mult_code,
  output logic                          iordy_en
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << FIELD_W;
  localparam logic [CNT_W-1:0] FMAX  = LIMIT - CNT_W'(1);
  localparam logic [1:0]       DMAX  = 2'(MAX_DBL);

  typedef enum logic {S_IDLE, S_FIT} st_t;

  st_t                          st_q, st_d;
  logic [NUM_T-1:0][CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]                   dbl_q, dbl_d;
  logic                         io_q, io_d;
  logic                         done_d, out_en;
  logic [NUM_T-1:0][FIELD_W-1:0] fields_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    dbl_d  = dbl_q;
    io_d   = io_q;
    done_d = 1'b0;
    out_en = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (load) begin
          cnt_d = cnt_in;
          dbl_d = 2'd0;
          io_d  = iordy_in;
          st_d  = S_FIT;
        end
      end
      default: begin
        if (cnt_q[IDX_STROBE] >= LIMIT && dbl_q != DMAX) begin
          for (int i = 0; i < NUM_T; i++) begin
            cnt_d[i] = CNT_W'(({1'b0, cnt_q[i]} + (CNT_W+1)'(1)) >> 1);
          end
          dbl_d = dbl_q + 2'd1;
        end else begin
          done_d = 1'b1;
          out_en = 1'b1;
          st_d   = S_IDLE;
        end
      end
    endcase
  end

  generate
    for (genvar g = 0; g < NUM_T; g++) begin : g_sat
      assign fields_d[g] = (cnt_q[g] > FMAX) ? FMAX[FIELD_W-1:0] : cnt_q[g][FIELD_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      dbl_q <= 2'd0;
      io_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dbl_q <= dbl_d;
      io_q  <= io_d;
      done  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields    <= '0;
      mult_code <= 2'b00;
      iordy_en  <= 1'b0;
    end else if (out_en) begin
      fields    <= fields_d;
      mult_code <= mult_encode(dbl_q);
      iordy_en  <= io_q;
    end
  end
endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int MHZ_W      = 11,
  parameter int FIELD_W    = 6,
  parameter int MAX_DBL    = 3,
  parameter int ADDR_SETUP = 1,
  parameter int LATCH_VAL  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [MHZ_W-1:0]   clk_mhz,
  output logic               done,
  output logic [FIELD_W-1:0] setup_cyc,
  output logic [FIELD_W-1:0] rd_width,
  output logic [FIELD_W-1:0] wr_width,
  output logic [FIELD_W-1:0] rd_hold,
  output logic [FIELD_W-1:0] wr_hold,
  output logic [1:0]         mult_code,
  output logic               iordy_en,
  output logic [3:0]         addr_setup,
  output logic [3:0]         latch_cyc
);
  localparam int CNT_W = NS_W + MHZ_W;

  ns_set_t                       ns_vals;
  logic                          iordy_lut;
  logic [NUM_T-1:0][CNT_W-1:0]   cyc;
  logic [NUM_T-1:0][FIELD_W-1:0] fields;

  ata_ns_lut u_lut (
    .mode    (mode),
    .ns_vals (ns_vals),
    .iordy   (iordy_lut)
  );

  generate
    for (genvar g = 0; g < NUM_T; g++) begin : g_conv
      ata_cyc_conv #(.NS_W(NS_W), .MHZ_W(MHZ_W), .CNT_W(CNT_W)) u_conv (
        .ns  (ns_vals[g]),
        .mhz (clk_mhz),
        .cyc (cyc[g])
      );
    end
  endgenerate

  ata_fit_seq #(.CNT_W(CNT_W), .FIELD_W(FIELD_W), .MAX_DBL(MAX_DBL)) u_fit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .cnt_in    (cyc),
    .iordy_in  (iordy_lut),
    .done      (done),
    .fields    (fields),
    .mult_code (mult_code),
    .iordy_en  (iordy_en)
  );

  assign setup_cyc  = fields[IDX_SETUP];
  assign rd_width   = fields[IDX_STROBE];
  assign wr_width   = fields[IDX_STROBE];
  assign rd_hold    = fields[IDX_HOLD];
  assign wr_hold    = fields[IDX_HOLD];
  assign addr_setup = 4'(ADDR_SETUP);
  assign latch_cyc  = 4'(LATCH_VAL);
endmodule

// File: rtl/ata_pio_timing_chk.sv
module ata_pio_timing_chk #(
  parameter int FIELD_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic [FIELD_W-1:0] setup_cyc,
  input logic [FIELD_W-1:0] rd_width,
  input logic [FIELD_W-1:0] rd_hold,
  input logic [1:0]         mult_code,
  input logic               iordy_en
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_width) && $stable(setup_cyc) && $stable(rd_hold)
               && $stable(mult_code) && $stable(iordy_en)));

  p_strobe_largest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (setup_cyc <= rd_width && rd_hold <= rd_width));

  p_fit_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mult_code != 2'b01) |-> (rd_width >= FIELD_W'(1 << (FIELD_W-2))));
endmodule

bind ata_pio_timing ata_pio_timing_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .setup_cyc (setup_cyc),
  .rd_width  (rd_width),
  .rd_hold   (rd_hold),
  .mult_code (mult_code),
  .iordy_en  (iordy_en)
);

// File: tb/ata_pio_timing_bench.sv
module ata_pio_timing_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start;
  logic [2:0]  mode;
  logic [10:0] clk_mhz;
  logic        done, iordy_en;
  logic [5:0]  setup_cyc, rd_width, wr_width, rd_hold, wr_hold;
  logic [1:0]  mult_code;
  logic [3:0]  addr_setup, latch_cyc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  ata_pio_timing u_ata_pio_timing (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .clk_mhz(clk_mhz),
    .done(done), .setup_cyc(setup_cyc), .rd_width(rd_width), .wr_width(wr_width),
    .rd_hold(rd_hold), .wr_hold(wr_hold), .mult_code(mult_code),
    .iordy_en(iordy_en), .addr_setup(addr_setup), .latch_cyc(latch_cyc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int conv(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic expect_vals(input int md, input int mhz,
                             output int s, output int w, output int h,
                             output int code, output int nd, output int io);
    int m, ns1, ns2, ns9;
    m = (md > 6) ? 0 : md;
    case (m)
      1: begin ns1 = 50; ns2 = 125; ns9 = 15; end
      2: begin ns1 = 30; ns2 = 100; ns9 = 10; end
      3: begin ns1 = 30; ns2 = 80;  ns9 = 10; end
      4: begin ns1 = 25; ns2 = 70;  ns9 = 10; end
      5: begin ns1 = 15; ns2 = 65;  ns9 = 10; end
      6: begin ns1 = 10; ns2 = 55;  ns9 = 10; end
      default: begin ns1 = 70; ns2 = 165; ns9 = 20; end
    endcase
    s = conv(ns1, mhz); w = conv(ns2, mhz); h = conv(ns9, mhz);
    nd = 0;
    while (w >= 64 && nd < 3) begin
      s = (s + 1) / 2; w = (w + 1) / 2; h = (h + 1) / 2; nd++;
    end
    if (s > 63) s = 63;
    if (w > 63) w = 63;
    if (h > 63) h = 63;
    case (nd)
      0: code = 1;
      1: code = 2;
      2: code = 0;
      default: code = 3;
    endcase
    io = (m <= 4) ? 1 : 0;
  endtask

  task automatic run(input int md, input int mhz, input bit poke);
    int s, w, h, code, nd, io, k;
    expect_vals(md, mhz, s, w, h, code, nd, io);
    @(negedge clk);
    start = 1'b1; mode = 3'(md); clk_mhz = 11'(mhz);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
      if (poke && k == 1) begin
        start = 1'b1; mode = 3'd6; clk_mhz = 11'd1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(poke ? "R10 latency with ignored start" : "R9 latency", k, 1 + nd);
    chk("R1 R3 setup_cyc", int'(setup_cyc), s);
    chk("R1 R3 rd_width", int'(rd_width), w);
    chk("R6 wr_width", int'(wr_width), w);
    chk("R1 R2 rd_hold", int'(rd_hold), h);
    chk("R6 wr_hold", int'(wr_hold), h);
    chk("R4 mult_code", int'(mult_code), code);
    chk("R5 iordy_en", int'(iordy_en), io);
    chk("R7 addr_setup", int'(addr_setup), 1);
    chk("R7 latch_cyc", int'(latch_cyc), 8);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
    chk("R9 outputs held", int'(rd_width), w);
  endtask

  initial begin
    start = 1'b0; mode = 3'd0; clk_mhz = 11'd0; rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset setup", int'(setup_cyc), 0);
    chk("R11 reset width", int'(rd_width), 0);
    chk("R11 reset hold", int'(rd_hold), 0);
    chk("R11 reset code", int'(mult_code), 0);
    chk("R11 reset iordy", int'(iordy_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run(0, 387, 1'b0);   // R3 strobe exactly 63, no halving
    run(0, 388, 1'b0);   // R3 strobe 64, one halving
    run(0, 2047, 1'b0);  // R3 R4 three doublings
    run(6, 1, 1'b0);     // R2 all counts reduce to zero
    run(3, 0, 1'b0);     // R2 zero count stays zero
    run(7, 500, 1'b0);   // R8 mode 7 as mode 0
    run(5, 200, 1'b0);   // R5 ready handshake off
    run(4, 200, 1'b0);   // R5 ready handshake on
    run(0, 2047, 1'b1);  // R10 start during computation ignored
    run(1, 1000, 1'b1);  // R10
    for (int i = 0; i < 300; i++) begin
      run(int'($urandom_range(0, 7)), int'($urandom_range(0, 2047)), 1'b0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule